// File: doc/BRIEF.md
# Vector Load Address Sequencer

This block turns one vector load command into a stream of byte addresses, one beat per memory access, for four addressing rules. These are contiguous (unit) access, constant byte stride, base plus per-element offset (indexed), and the segmented form of each, where every element is a record of several equal-width fields placed back to back. The command carries the rule, a 64-bit base, a signed 64-bit stride, two width codes, the field count, the element count and a per-element enable mask. In indexed mode a separate stream supplies one signed 64-bit offset per element.

Each output beat carries the address, the element number and the field number. Beats appear in ascending element order, and within an element in ascending field order. Disabled elements produce no beat, but their element number is still used up, and in indexed mode their offset is still consumed. Both streams use valid/ready. A beat is transferred on a rising edge where valid and ready are both high. While valid is high and ready is low, the beat's address, element and field stay unchanged. The source of the offset stream may hold or change its data freely until it is accepted. A one-cycle `done` pulse marks the end of a command. A new command is accepted only while `cmd_ready` is high.

Top module: `vld_addr_gen`

## Requirements
- R1: After reset, `cmd_ready` is 1 and `req_valid`, `idx_ready` and `done` are 0.
- R2: Mode code 0 (unit) with one field: element i is at base + i·W, where W = 2^`cmd_eew` bytes (code 0..3 → 1, 2, 4, 8 bytes).
- R3: Mode code 1 (strided): the record of element i starts at base + i·stride, with the stride signed (two's complement, wrapping at 64 bits).
- R4: Mode code 2 (indexed): the record of element i starts at base + idx[i], the i-th offset taken from the offset stream, signed, always relative to the base.
- R5: The field width W comes from `cmd_sew` in indexed mode and from `cmd_eew` in modes 0 and 1; the other width code has no effect.
- R6: With NF = `cmd_nf`+1 fields, field f of a record is at record start + f·W. In unit mode the records are contiguous: record i starts at base + i·NF·W.
- R7: An element whose `cmd_mask` bit i is 0 emits no beat, while later beats keep their true element numbers.
- R8: Beats come in ascending element order and, within an element, in fields 0..NF-1.
- R9: While `req_valid` is 1 and `req_ready` is 0, the next cycle keeps `req_valid` high with the same address, element and field.
- R10: `cmd_ready` is 0 from command acceptance until the end of the command. `done` is a single-cycle pulse after the last element. A command with `cmd_vl` = 0 yields `done` and no beats.
- R11: In indexed mode exactly `cmd_vl` offsets are accepted, one per element, masked ones included. `idx_ready` is never high in the same cycle as `req_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Sequencer idle, command taken |
| cmd_mode | input | 2 | 0 unit, 1 strided, 2 indexed (3 acts as unit) |
| cmd_base | input | 64 | Base byte address |
| cmd_stride | input | 64 | Signed byte stride between records |
| cmd_eew | input | 2 | Encoded width code (data in modes 0/1) |
| cmd_sew | input | 2 | Configured width code (data in mode 2) |
| cmd_nf | input | 3 | Field count minus one |
| cmd_vl | input | 7 | Number of elements, 0..64 |
| cmd_mask | input | 64 | Per-element enable, bit i for element i |
| idx_valid | input | 1 | Offset present |
| idx_ready | output | 1 | Offset accepted |
| idx_data | input | 64 | Signed byte offset of the current element |
| req_valid | output | 1 | Address beat present |
| req_ready | input | 1 | Consumer accepts beat |
| req_addr | output | 64 | Byte address |
| req_elem | output | 7 | Element number |
| req_field | output | 3 | Field number |
| done | output | 1 | End-of-command pulse |

## Verification
The checker assumes that the command fields stay meaningful only while they are being accepted. It also assumes that `cmd_vl` never exceeds 64 and that the consumer may stall at any time without limit. The bench drives commands only at idle, so the stimulus stays within these assumptions. It offers exactly `cmd_vl` offsets per indexed command and applies a periodic ready pattern that produces repeated stalls mid-record. The ordering property relies on the element number never decreasing within a command. The beat that follows the last beat of a command is always absent, because a command ends only after one idle cycle.

// File: rtl/vld_addr_pkg.sv
package vld_addr_pkg;
  typedef enum logic [1:0] {
    AM_UNIT   = 2'd0,
    AM_STRIDE = 2'd1,
    AM_INDEX  = 2'd2,
    AM_RSVD   = 2'd3
  } amode_t;

  // width code selection: indexed records use the configured width
  function automatic logic [1:0] pick_wcode(amode_t m, logic [1:0] enc_w, logic [1:0] cfg_w);
    return (m == AM_INDEX) ? cfg_w : enc_w;
  endfunction
endpackage

// File: rtl/vld_elem_seq.sv
module vld_elem_seq #(
  parameter int VL_MAX = 64,
  parameter int NF_W   = 3,
  localparam int VL_W  = $clog2(VL_MAX + 1),
  localparam int MI_W  = (VL_MAX > 1) ? $clog2(VL_MAX) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [VL_W-1:0]   cfg_vl,
  input  logic [NF_W-1:0]   cfg_nf,
  input  logic [VL_MAX-1:0] cfg_mask,
  input  logic              beat_fire,
  input  logic              skip,
  output logic [VL_W-1:0]   elem,
  output logic [NF_W-1:0]   field,
  output logic              at_end,
  output logic              elem_on,
  output logic              elem_adv
);
  logic last_field;

  assign at_end     = (elem == cfg_vl);
  assign elem_on    = cfg_mask[elem[MI_W-1:0]];
  assign last_field = (field == cfg_nf);
  assign elem_adv   = skip | (beat_fire & last_field);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      elem  <= '0;
      field <= '0;
    end else if (start) begin
      elem  <= '0;
      field <= '0;
    end else if (elem_adv) begin
      elem  <= elem + VL_W'(1);
      field <= '0;
    end else if (beat_fire) begin
      field <= field + NF_W'(1);
    end
  end
endmodule

// File: rtl/vld_addr_unit.sv
module vld_addr_unit
  import vld_addr_pkg::*;
#(
  parameter int AW   = 64,
  parameter int NF_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [AW-1:0]   start_base,
  input  amode_t          mode,
  input  logic [AW-1:0]   base,
  input  logic [AW-1:0]   stride,
  input  logic [1:0]      wcode,
  input  logic [NF_W-1:0] nf_m1,
  input  logic [NF_W-1:0] field,
  input  logic            elem_adv,
  input  logic            idx_fire,
  input  logic [AW-1:0]   idx_data,
  output logic            idx_have,
  output logic [AW-1:0]   addr
);
  logic [AW-1:0]  rec_start;
  logic [AW-1:0]  rec_step;
  logic [NF_W:0]  nf_cnt;

  assign nf_cnt = {1'b0, nf_m1} + (NF_W + 1)'(1);

  generate
    if (AW > NF_W + 1) begin : g_step
      always_comb begin
        if (mode == AM_STRIDE) rec_step = stride;
        else                   rec_step = {{(AW-NF_W-1){1'b0}}, nf_cnt} << wcode;
      end
      assign addr = rec_start + ({{(AW-NF_W){1'b0}}, field} << wcode);
    end else begin : g_step_narrow
      always_comb begin
        if (mode == AM_STRIDE) rec_step = stride;
        else                   rec_step = AW'(nf_cnt) << wcode;
      end
      assign addr = rec_start + (AW'(field) << wcode);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rec_start <= '0;
      idx_have  <= 1'b0;
    end else if (start) begin
      rec_start <= start_base;
      idx_have  <= 1'b0;
    end else if (idx_fire) begin
      rec_start <= base + idx_data;
      idx_have  <= 1'b1;
    end else if (elem_adv) begin
      if (mode != AM_INDEX) rec_start <= rec_start + rec_step;
      idx_have <= 1'b0;
    end
  end
endmodule

// File: rtl/vld_addr_gen.sv
module vld_addr_gen
  import vld_addr_pkg::*;
#(
  parameter int AW     = 64,
  parameter int VL_MAX = 64,
  parameter int NF_MAX = 8,
  localparam int VL_W  = $clog2(VL_MAX + 1),
  localparam int NF_W  = (NF_MAX > 1) ? $clog2(NF_MAX) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_mode,
  input  logic [AW-1:0]     cmd_base,
  input  logic [AW-1:0]     cmd_stride,
  input  logic [1:0]        cmd_eew,
  input  logic [1:0]        cmd_sew,
  input  logic [NF_W-1:0]   cmd_nf,
  input  logic [VL_W-1:0]   cmd_vl,
  input  logic [VL_MAX-1:0] cmd_mask,
  input  logic              idx_valid,
  output logic              idx_ready,
  input  logic [AW-1:0]     idx_data,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [AW-1:0]     req_addr,
  output logic [VL_W-1:0]   req_elem,
  output logic [NF_W-1:0]   req_field,
  output logic              done
);
  logic              busy;
  amode_t            mode_r;
  logic [AW-1:0]     base_r, stride_r;
  logic [1:0]        wcode_r;
  logic [NF_W-1:0]   nf_r;
  logic [VL_W-1:0]   vl_r;
  logic [VL_MAX-1:0] mask_r;

  logic start, at_end, elem_on, elem_adv, idx_have;
  logic beat_fire, skip, idx_fire, is_idx;
  logic [VL_W-1:0] elem;
  logic [NF_W-1:0] field;

  assign cmd_ready = !busy;
  assign start     = cmd_valid && !busy;
  assign is_idx    = (mode_r == AM_INDEX);

  assign idx_ready = busy && !at_end && is_idx && !idx_have;
  assign idx_fire  = idx_ready && idx_valid;
  assign req_valid = busy && !at_end && elem_on && (!is_idx || idx_have);
  assign beat_fire = req_valid && req_ready;
  assign skip      = busy && !at_end && !elem_on && (!is_idx || idx_have);
  assign req_elem  = elem;
  assign req_field = field;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      mode_r   <= AM_UNIT;
      base_r   <= '0;
      stride_r <= '0;
      wcode_r  <= '0;
      nf_r     <= '0;
      vl_r     <= '0;
      mask_r   <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy     <= 1'b1;
        mode_r   <= amode_t'(cmd_mode);
        base_r   <= cmd_base;
        stride_r <= cmd_stride;
        wcode_r  <= pick_wcode(amode_t'(cmd_mode), cmd_eew, cmd_sew);
        nf_r     <= cmd_nf;
        vl_r     <= cmd_vl;
        mask_r   <= cmd_mask;
      end else if (busy && at_end) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end

  vld_elem_seq #(.VL_MAX(VL_MAX), .NF_W(NF_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .cfg_vl    (vl_r),
    .cfg_nf    (nf_r),
    .cfg_mask  (mask_r),
    .beat_fire (beat_fire),
    .skip      (skip),
    .elem      (elem),
    .field     (field),
    .at_end    (at_end),
    .elem_on   (elem_on),
    .elem_adv  (elem_adv)
  );

  vld_addr_unit #(.AW(AW), .NF_W(NF_W)) u_addr (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_base (cmd_base),
    .mode       (mode_r),
    .base       (base_r),
    .stride     (stride_r),
    .wcode      (wcode_r),
    .nf_m1      (nf_r),
    .field      (field),
    .elem_adv   (elem_adv),
    .idx_fire   (idx_fire),
    .idx_data   (idx_data),
    .idx_have   (idx_have),
    .addr       (req_addr)
  );
endmodule

// File: rtl/vld_addr_gen_chk.sv
module vld_addr_gen_chk #(
  parameter int AW   = 64,
  parameter int VL_W = 7,
  parameter int NF_W = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmd_ready,
  input logic            idx_ready,
  input logic            req_valid,
  input logic            req_ready,
  input logic [AW-1:0]   req_addr,
  input logic [VL_W-1:0] req_elem,
  input logic [NF_W-1:0] req_field,
  input logic            done
);
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) &&
                                   $stable(req_elem) && $stable(req_field)));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cmd_ready);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (!req_valid && !idx_ready));

  assert_no_overlap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    idx_ready |-> !req_valid);

  assert_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!req_valid || (req_elem > $past(req_elem)) ||
      ((req_elem == $past(req_elem)) && (req_field == $past(req_field) + NF_W'(1)))));
endmodule

bind vld_addr_gen vld_addr_gen_chk #(.AW(AW), .VL_W(VL_W), .NF_W(NF_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_ready (cmd_ready),
  .idx_ready (idx_ready),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_addr  (req_addr),
  .req_elem  (req_elem),
  .req_field (req_field),
  .done      (done)
);

// File: tb/vld_addr_gen_bench.sv
module vld_addr_gen_bench;
  localparam int AW = 64;
  localparam int VLM = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic cmd_valid = 1'b0, cmd_ready;
  logic [1:0] cmd_mode = '0, cmd_eew = '0, cmd_sew = '0;
  logic [AW-1:0] cmd_base = '0, cmd_stride = '0;
  logic [2:0] cmd_nf = '0;
  logic [6:0] cmd_vl = '0;
  logic [VLM-1:0] cmd_mask = '0;
  logic idx_valid = 1'b0, idx_ready;
  logic [AW-1:0] idx_data = '0;
  logic req_valid, req_ready = 1'b0;
  logic [AW-1:0] req_addr;
  logic [6:0] req_elem;
  logic [2:0] req_field;
  logic done;

  vld_addr_gen u_vld_addr_gen (.*);

  int checks = 0, fails = 0, cyc = 0;
  bit bp_on = 1'b0;
  string cur_tag = "R1";
  logic [AW-1:0] exp_addr[$];
  int exp_elem[$], exp_field[$];
  logic [AW-1:0] iq[$];
  bit prev_stall = 1'b0;
  logic [AW-1:0] pa; logic [6:0] pe; logic [2:0] pf;

  task automatic chk(string tag, bit ok, logic [AW-1:0] act, logic [AW-1:0] exp, string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // stream driver and beat collector
  always @(negedge clk) begin
    cyc++;
    req_ready = bp_on ? ((cyc % 3) != 1) : 1'b1;
    idx_valid = (iq.size() > 0);
    idx_data  = (iq.size() > 0) ? iq[0] : '0;
    #1;
    if (rst_n) begin
      if (prev_stall)
        chk("R9", req_valid && req_addr == pa && req_elem == pe && req_field == pf,
            {req_valid, req_addr[31:0]}, {1'b1, pa[31:0]}, "stalled beat held");
      if (req_valid && req_ready) begin
        if (exp_addr.size() == 0) begin
          chk(cur_tag, 1'b0, req_addr, '0, "unexpected beat");
        end else begin
          chk(cur_tag, req_addr == exp_addr[0], req_addr, exp_addr[0], "address");
          chk({cur_tag, "/R8"}, req_elem == 7'(exp_elem[0]) && req_field == 3'(exp_field[0]),
              {req_elem, req_field}, {7'(exp_elem[0]), 3'(exp_field[0])}, "elem/field");
          void'(exp_addr.pop_front()); void'(exp_elem.pop_front()); void'(exp_field.pop_front());
        end
      end
      if (idx_valid && idx_ready) void'(iq.pop_front());
      prev_stall = req_valid && !req_ready;
      pa = req_addr; pe = req_elem; pf = req_field;
    end
  end

  // reference model built from the requirements
  task automatic run(string tag, int mode, logic [AW-1:0] base, logic [AW-1:0] stride,
                     int eew, int sew, int nf, int vl, logic [VLM-1:0] mask,
                     logic [AW-1:0] idx[$], bit bp);
    int w = 1 << ((mode == 2) ? sew : eew);
    int n;
    logic [AW-1:0] rs;
    cur_tag = tag; bp_on = bp;
    for (int i = 0; i < vl; i++) begin
      if (mode == 2) iq.push_back(idx[i]);
      if (mask[i]) begin
        if (mode == 1)      rs = base + AW'(i) * stride;
        else if (mode == 2) rs = base + idx[i];
        else                rs = base + AW'(i * nf * w);
        for (int f = 0; f < nf; f++) begin
          exp_addr.push_back(rs + AW'(f * w));
          exp_elem.push_back(i); exp_field.push_back(f);
        end
      end
    end
    @(negedge clk);
    cmd_valid = 1'b1; cmd_mode = 2'(mode); cmd_base = base; cmd_stride = stride;
    cmd_eew = 2'(eew); cmd_sew = 2'(sew); cmd_nf = 3'(nf - 1); cmd_vl = 7'(vl); cmd_mask = mask;
    @(negedge clk);
    cmd_valid = 1'b0;
    #2;
    chk("R10", cmd_ready == 1'b0, cmd_ready, 0, "busy after accept");
    n = 0;
    while (!done && n < 2000) begin @(negedge clk); #2; n++; end
    chk("R10", done == 1'b1, done, 1, "done seen");
    chk(tag, exp_addr.size() == 0, exp_addr.size(), 0, "beats missing");
    chk("R11", iq.size() == 0, iq.size(), 0, "offsets left unconsumed");
    @(negedge clk); #2;
    chk("R10", done == 1'b0, done, 0, "done single cycle");
    exp_addr.delete(); exp_elem.delete(); exp_field.delete(); iq.delete();
  endtask

  task automatic t_reset;
    #2;
    chk("R1", cmd_ready && !req_valid && !idx_ready && !done,
        {cmd_ready, req_valid, idx_ready, done}, 4'b1000, "reset state");
  endtask

  task automatic t_unit;
    logic [AW-1:0] none[$];
    run("R2", 0, 64'h1000, 64'd0, 2, 0, 1, 5, '1, none, 1'b0);
    run("R2", 0, 64'h2003, 64'd0, 3, 0, 1, 3, '1, none, 1'b1);
  endtask

  task automatic t_unit_seg;
    logic [AW-1:0] none[$];
    // sew differs from eew: must not change the width (R5)
    run("R6", 0, 64'h4000, 64'd0, 1, 3, 3, 4, '1, none, 1'b1);
  endtask

  task automatic t_stride;
    logic [AW-1:0] none[$];
    run("R3", 1, 64'h9000, -64'sd24, 3, 0, 2, 4, '1, none, 1'b1);
    run("R3", 1, 64'h100, 64'd40, 0, 2, 1, 6, '1, none, 1'b0);
  endtask

  task automatic t_index;
    logic [AW-1:0] ix[$];
    ix = '{64'd100, -64'sd16, 64'd0, 64'd40};
    run("R4/R5", 2, 64'h8000, 64'd0, 3, 1, 2, 4, '1, ix, 1'b1);
  endtask

  task automatic t_mask;
    logic [AW-1:0] none[$];
    logic [AW-1:0] ix[$];
    run("R7", 0, 64'h500, 64'd0, 0, 0, 1, 8, 64'hA6, none, 1'b0);
    ix = '{64'd8, 64'd16, 64'd24, 64'd32, 64'd48};
    run("R7/R11", 2, 64'h600, 64'd0, 0, 2, 3, 5, 64'b10110, ix, 1'b1);
  endtask

  task automatic t_empty;
    logic [AW-1:0] none[$];
    run("R10", 1, 64'h700, 64'd8, 2, 0, 2, 0, '1, none, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_unit();
    t_unit_seg();
    t_stride();
    t_index();
    t_mask();
    t_empty();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired (actual hung, expected finish)");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule